// File: doc/BRIEF.md
# Double-buffered DMA channel controller

This block holds six independent peripheral DMA channels. Each channel moves data between one peripheral request source and memory. It works through two buffer descriptors, A and B, and alternates between them, so software can refill one buffer while the other is being drained. Each descriptor is a start address and a byte count of up to 13 bits, which allows at most 0x1FFF bytes per buffer.

Software controls a channel through a control word with three aliases. Writing ones to the set alias raises bits. Writing ones to the clear alias drops bits. The read alias returns the live value. To pause a channel, software drops the run and interrupt-enable bits; the working address and count are kept, and raising the same bits again resumes the transfer at the same point. To abandon a channel, software drops the run, interrupt-enable and both start bits in one write.

A started channel asks for a memory beat whenever its peripheral strobe is high. The lowest-numbered requesting channel wins the single memory port. When a buffer's count runs out, the channel marks that buffer finished and raises its interrupt if enabled. It then moves to the other buffer.

Top module: `dmac_top`

## Requirements
- R1: After reset, every control word reads zero, `irq` is all zero and `mem_req` is low.
- R2: Register address is `reg_addr[5:3]` = channel and `reg_addr[2:0]` = register (0 set alias, 1 clear alias, 2 control read, 3 address A, 4 count A, 5 address B, 6 count B, 7 position). A write to the set alias raises each of RUN (bit 0), IE (bit 1), GO_A (bit 3) and GO_B (bit 5) whose data bit is 1. It leaves the other bits alone, including FIN_A (bit 2) and FIN_B (bit 4).
- R3: A write to the clear alias drops each of bits 0 to 5 whose data bit is 1. RUN falls only through such a write.
- R4: The control read returns {NXT_B (bit 6), GO_B, FIN_B, GO_A, FIN_A, IE, RUN}, with zeros above bit 6. NXT_B is 1 when buffer B is the next one to be used.
- R5: `mem_req` is high exactly when some channel has RUN set, the start bit of its next buffer set and its `per_req` strobe high. The lowest such channel index is presented on `mem_ch`, and its working address is presented on `mem_addr`. A beat completes in a cycle with `mem_req` and `mem_gnt` both high.
- R6: Each completed beat adds the step to the buffer's address and subtracts the step from its count. The step is 2 on channels marked 16-bit (channel 5 by default, also flagged on `mem_half`) and 1 on the others.
- R7: A beat that leaves the count at zero (or would take it below zero) clears that buffer's start bit, sets its finished bit and flips NXT_B. The channel then carries on with the other buffer if that buffer is started.
- R8: If neither start bit is set, the channel issues no request and RUN stays set.
- R9: If the next buffer is not started but the other one is, NXT_B moves to the started buffer on the following clock.
- R10: Clearing RUN and IE stops requests and keeps the address, count and start bits. Setting them again resumes at the same address.
- R11: `irq[n]` is high when channel n has IE set and FIN_A or FIN_B set. Writing ones to bits 2 and 4 through the clear alias removes it.
- R12: The position register returns the working address of the next buffer.
- R13: Writes to channel numbers 6 and 7 have no effect, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Channel (bits 5:3) and register index (bits 2:0) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| per_req | input | 6 | Peripheral request strobe, one per channel |
| mem_req | output | 1 | Memory beat request |
| mem_gnt | input | 1 | Memory accepts the beat this cycle |
| mem_addr | output | 32 | Byte address of the beat |
| mem_ch | output | 3 | Channel that owns the beat |
| mem_half | output | 1 | Beat is 16 bits wide |
| irq | output | 6 | Per-channel interrupt |

## Verification
The bench pauses a channel in the middle of a buffer. A design that lost its place would resume from the start address, or from an address one beat off, and the scoreboard would see the wrong beat sequence. Two channels that request together must be served strictly in priority order, including while the memory port stalls; an arbiter that rotated or dropped the stalled request would change the order of the queued beats. The bench abandons a channel, then starts only buffer B. This catches a design that keeps waiting on buffer A, and it checks that a finished buffer raises no interrupt while IE is clear. A 16-bit channel with an odd count checks that the final beat ends the buffer rather than wrapping the count.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the DMA channel controller: control-word bit
// positions and register index codes. Assumes a 3-bit register index.
package dmac_pkg;
    localparam int B_RUN   = 0;
    localparam int B_IE    = 1;
    localparam int B_FIN_A = 2;
    localparam int B_GO_A  = 3;
    localparam int B_FIN_B = 4;
    localparam int B_GO_B  = 5;
    localparam int B_NXT   = 6;
    localparam int CTL_W   = 7;

    typedef enum logic [2:0] {
        RI_SET  = 3'd0,
        RI_CLR  = 3'd1,
        RI_CTL  = 3'd2,
        RI_ADRA = 3'd3,
        RI_CNTA = 3'd4,
        RI_ADRB = 3'd5,
        RI_CNTB = 3'd6,
        RI_POS  = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/dmac_chan.sv
`timescale 1ns/1ps
// One DMA channel: control bits, two buffer descriptors that also serve as
// working address/count, ping-pong selection and interrupt. Assumes the
// arbiter raises beat only while want is high. Software writes are merged
// after the hardware update, so in a clash the software value wins.
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 13,
    parameter bit HALF  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic             adra_we,
    input  logic             cnta_we,
    input  logic             adrb_we,
    input  logic             cntb_we,
    input  logic [AW-1:0]    wdata,
    input  logic             per_req,
    input  logic             beat,
    output logic             want,
    output logic [AW-1:0]    pos,
    output logic [CTL_W-1:0] ctl,
    output logic [AW-1:0]    adr_a,
    output logic [AW-1:0]    adr_b,
    output logic [CNT_W-1:0] cnt_a,
    output logic [CNT_W-1:0] cnt_b,
    output logic             irq
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(HALF ? 2 : 1);

    logic                     run_q, ie_q, sel_q;
    logic [1:0]               go_q, fin_q;
    logic [1:0][AW-1:0]       adr_q;
    logic [1:0][CNT_W-1:0]    cnt_q;
    logic                     run_n, ie_n, sel_n;
    logic [1:0]               go_n, fin_n;
    logic [1:0][AW-1:0]       adr_n;
    logic [1:0][CNT_W-1:0]    cnt_n;
    logic                     last;

    assign want  = run_q && go_q[sel_q] && per_req;
    assign last  = beat && (cnt_q[sel_q] <= STEP);
    assign pos   = adr_q[sel_q];
    assign ctl   = {sel_q, go_q[1], fin_q[1], go_q[0], fin_q[0], ie_q, run_q};
    assign adr_a = adr_q[0];
    assign adr_b = adr_q[1];
    assign cnt_a = cnt_q[0];
    assign cnt_b = cnt_q[1];
    assign irq   = ie_q && (fin_q != 2'b00);

    // Next state: hardware progress first, then software set/clear and loads.
    always_comb begin
        run_n = run_q;
        ie_n  = ie_q;
        sel_n = sel_q;
        go_n  = go_q;
        fin_n = fin_q;
        adr_n = adr_q;
        cnt_n = cnt_q;
        if (beat) begin
            adr_n[sel_q] = adr_q[sel_q] + AW'(STEP);
            cnt_n[sel_q] = last ? '0 : cnt_q[sel_q] - STEP;
            if (last) begin
                go_n[sel_q]  = 1'b0;
                fin_n[sel_q] = 1'b1;
                sel_n        = !sel_q;
            end
        end else if (!go_q[sel_q] && go_q[!sel_q]) begin
            sel_n = !sel_q;
        end
        if (set_we) begin
            run_n    = run_n    | wdata[B_RUN];
            ie_n     = ie_n     | wdata[B_IE];
            go_n[0]  = go_n[0]  | wdata[B_GO_A];
            go_n[1]  = go_n[1]  | wdata[B_GO_B];
        end
        if (clr_we) begin
            run_n    = run_n    & ~wdata[B_RUN];
            ie_n     = ie_n     & ~wdata[B_IE];
            go_n[0]  = go_n[0]  & ~wdata[B_GO_A];
            go_n[1]  = go_n[1]  & ~wdata[B_GO_B];
            fin_n[0] = fin_n[0] & ~wdata[B_FIN_A];
            fin_n[1] = fin_n[1] & ~wdata[B_FIN_B];
        end
        if (adra_we) adr_n[0] = wdata;
        if (adrb_we) adr_n[1] = wdata;
        if (cnta_we) cnt_n[0] = wdata[CNT_W-1:0];
        if (cntb_we) cnt_n[1] = wdata[CNT_W-1:0];
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ie_q  <= 1'b0;
            sel_q <= 1'b0;
            go_q  <= '0;
            fin_q <= '0;
            adr_q <= '0;
            cnt_q <= '0;
        end else begin
            run_q <= run_n;
            ie_q  <= ie_n;
            sel_q <= sel_n;
            go_q  <= go_n;
            fin_q <= fin_n;
            adr_q <= adr_n;
            cnt_q <= cnt_n;
        end
    end
endmodule

// File: rtl/dmac_arb.sv
`timescale 1ns/1ps
// Fixed-priority selector for the single memory port: the lowest channel
// index that wants a beat owns the port. Purely combinational.
module dmac_arb #(
    parameter int N    = 6,
    parameter int CH_W = 3
) (
    input  logic [N-1:0]    want,
    input  logic            gnt,
    output logic            req,
    output logic [CH_W-1:0] ch,
    output logic [N-1:0]    beat
);
    assign req = |want;

    // Pick the lowest requesting index and route the grant back to it.
    always_comb begin
        ch   = '0;
        beat = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (want[i]) ch = CH_W'(i);
        end
        for (int i = 0; i < N; i++) begin
            beat[i] = want[i] && gnt && (ch == CH_W'(i));
        end
    end
endmodule

// File: rtl/dmac_top.sv
`timescale 1ns/1ps
// Bank of double-buffered DMA channels with a set/clear/read register
// interface and one shared memory port. Assumes reg_wdata is as wide as an
// address and that reads are combinational from reg_addr.
module dmac_top
    import dmac_pkg::*;
#(
    parameter int NUM_CH  = 6,
    parameter int AW      = 32,
    parameter int CNT_W   = 13,
    parameter logic [NUM_CH-1:0] WIDE_MASK = {1'b1, {(NUM_CH-1){1'b0}}},
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [CH_W+2:0]   reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    input  logic [NUM_CH-1:0] per_req,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic [AW-1:0]     mem_addr,
    output logic [CH_W-1:0]   mem_ch,
    output logic              mem_half,
    output logic [NUM_CH-1:0] irq
);
    logic [CH_W-1:0]               a_ch;
    reg_idx_e                      a_idx;
    logic                          a_ok;
    logic [NUM_CH-1:0]             want, beat;
    logic [NUM_CH-1:0][AW-1:0]     pos, adr_a, adr_b;
    logic [NUM_CH-1:0][CNT_W-1:0]  cnt_a, cnt_b;
    logic [NUM_CH-1:0][CTL_W-1:0]  ctl_w;

    assign a_ch  = reg_addr[CH_W+2:3];
    assign a_idx = reg_idx_e'(reg_addr[2:0]);
    assign a_ok  = (32'(a_ch) < NUM_CH);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = reg_wr && (a_ch == CH_W'(i));
        dmac_chan #(.AW(AW), .CNT_W(CNT_W), .HALF(WIDE_MASK[i])) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_we  (hit && a_idx == RI_SET),
            .clr_we  (hit && a_idx == RI_CLR),
            .adra_we (hit && a_idx == RI_ADRA),
            .cnta_we (hit && a_idx == RI_CNTA),
            .adrb_we (hit && a_idx == RI_ADRB),
            .cntb_we (hit && a_idx == RI_CNTB),
            .wdata   (reg_wdata),
            .per_req (per_req[i]),
            .beat    (beat[i]),
            .want    (want[i]),
            .pos     (pos[i]),
            .ctl     (ctl_w[i]),
            .adr_a   (adr_a[i]),
            .adr_b   (adr_b[i]),
            .cnt_a   (cnt_a[i]),
            .cnt_b   (cnt_b[i]),
            .irq     (irq[i])
        );
    end

    dmac_arb #(.N(NUM_CH), .CH_W(CH_W)) arb_i (
        .want (want),
        .gnt  (mem_gnt),
        .req  (mem_req),
        .ch   (mem_ch),
        .beat (beat)
    );

    assign mem_addr = pos[mem_ch];
    assign mem_half = WIDE_MASK[mem_ch];

    // Readback mux: live control word, descriptors and position.
    always_comb begin
        reg_rdata = '0;
        if (a_ok) begin
            case (a_idx)
                RI_CTL:  reg_rdata = AW'(ctl_w[a_ch]);
                RI_ADRA: reg_rdata = adr_a[a_ch];
                RI_CNTA: reg_rdata = AW'(cnt_a[a_ch]);
                RI_ADRB: reg_rdata = adr_b[a_ch];
                RI_CNTB: reg_rdata = AW'(cnt_b[a_ch]);
                RI_POS:  reg_rdata = pos[a_ch];
                default: reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dmac_chk.sv
`timescale 1ns/1ps
// Protocol checker for dmac_top, attached by bind. Observes the memory
// port, register writes and the per-channel control words.
module dmac_chk
    import dmac_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CH_W   = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic [CH_W+2:0]              reg_addr,
    input  logic                         mem_req,
    input  logic [CH_W-1:0]              mem_ch,
    input  logic [NUM_CH-1:0]            per_req,
    input  logic [NUM_CH-1:0]            irq,
    input  logic [NUM_CH-1:0][CTL_W-1:0] ctl_w,
    input  logic [NUM_CH-1:0]            beat
);
    AST_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(beat)); // R5
    AST_REQ_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> per_req[mem_ch]); // R5
    AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ctl_w[mem_ch][B_RUN]); // R8

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_RUN_FALLS_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ctl_w[i][B_RUN]) |-> $past(reg_wr && reg_addr == {CH_W'(i), 3'd1})); // R3
        AST_FIN_A_BY_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ctl_w[i][B_FIN_A]) |-> $past(beat[i])); // R7
        AST_FIN_B_BY_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ctl_w[i][B_FIN_B]) |-> $past(beat[i])); // R7
        AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> ctl_w[i][B_IE]); // R11
    end
endmodule

bind dmac_top dmac_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .mem_req  (mem_req),
    .mem_ch   (mem_ch),
    .per_req  (per_req),
    .irq      (irq),
    .ctl_w    (ctl_w),
    .beat     (beat)
);

// File: tb/dmac_top_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: tasks queue the expected memory beats, a monitor pops
// and compares them as the design issues them; register checks are direct.
module dmac_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  per_req = '0;
    logic        mem_req;
    logic        mem_gnt = 1'b0;
    logic [31:0] mem_addr;
    logic [2:0]  mem_ch;
    logic        mem_half;
    logic [5:0]  irq;

    typedef struct { int ch; logic [31:0] adr; } beat_t;
    beat_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rd_v;

    always #2 clk = ~clk;

    dmac_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
        .mem_ch(mem_ch), .mem_half(mem_half), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int idx, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = {3'(ch), 3'(idx)}; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int ch, input int idx, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = {3'(ch), 3'(idx)};
        #1 d = reg_rdata;
    endtask

    task automatic expect_beats(input int ch, input logic [31:0] base, input int n, input int stp);
        for (int k = 0; k < n; k++) begin
            beat_t b;
            b.ch = ch; b.adr = base + 32'(k * stp);
            q.push_back(b);
        end
    endtask

    task automatic drain();
        int k = 0;
        while (q.size() != 0 && k < 500) begin
            @(posedge clk); k++;
        end
        repeat (3) @(posedge clk);
        chk("R5 scoreboard empty", 32'(q.size()), 32'd0);
    endtask

    // Monitor: every accepted beat must match the head of the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req && mem_gnt) begin
                if (q.size() == 0) begin
                    chk("R5 unexpected beat", {29'd0, mem_ch}, 32'hFFFF_FFFF);
                end else begin
                    beat_t e;
                    e = q.pop_front();
                    chk("R5 beat channel", {29'd0, mem_ch}, 32'(e.ch));
                    chk("R6 beat address", mem_addr, e.adr);
                    chk("R6 beat width", {31'd0, mem_half}, {31'd0, e.ch == 5});
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk("R1 irq", {26'd0, irq}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
        rd(0, 2, rd_v); chk("R1 ctl ch0", rd_v, 32'd0);
        rd(5, 2, rd_v); chk("R1 ctl ch5", rd_v, 32'd0);

        // Ping-pong on channel 0: A then B, then idle with RUN kept.
        wr(0, 3, 32'h1000); wr(0, 4, 32'd3);
        wr(0, 5, 32'h2000); wr(0, 6, 32'd2);
        wr(0, 0, 32'h2B);
        rd(0, 2, rd_v); chk("R2 R4 set alias ch0", rd_v, 32'h2B);
        rd(0, 7, rd_v); chk("R12 position A", rd_v, 32'h1000);
        expect_beats(0, 32'h1000, 3, 1);
        expect_beats(0, 32'h2000, 2, 1);
        mem_gnt = 1'b1;
        @(posedge clk); #1 per_req[0] = 1'b1;
        drain();
        rd(0, 2, rd_v); chk("R7 R8 ch0 both done", rd_v, 32'h17);
        chk("R11 irq ch0 raised", {31'd0, irq[0]}, 32'd1);
        chk("R8 idle no request", {31'd0, mem_req}, 32'd0);
        wr(0, 1, 32'h14);
        rd(0, 2, rd_v); chk("R11 fin cleared", rd_v, 32'h03);
        chk("R11 irq ch0 removed", {31'd0, irq[0]}, 32'd0);

        // Pause and resume on channel 1.
        wr(1, 3, 32'h3000); wr(1, 4, 32'd6);
        wr(1, 0, 32'h0B);
        expect_beats(1, 32'h3000, 6, 1);
        @(posedge clk); #1 per_req[1] = 1'b1;
        wr(1, 1, 32'h03);
        repeat (4) @(posedge clk);
        rd(1, 7, rd_v); chk("R10 R12 paused position", rd_v, 32'h3002);
        rd(1, 4, rd_v); chk("R10 paused count", rd_v, 32'd4);
        rd(1, 2, rd_v); chk("R10 paused ctl", rd_v, 32'h08);
        chk("R10 no request while paused", {31'd0, mem_req}, 32'd0);
        chk("R10 queue holds rest", 32'(q.size()), 32'd4);
        wr(1, 0, 32'h03);
        drain();
        rd(1, 2, rd_v); chk("R7 ch1 done next B", rd_v, 32'h47);
        chk("R11 irq ch1", {31'd0, irq[1]}, 32'd1);

        // Priority and stall: channels 2 and 3 together.
        wr(2, 0, 32'h14);
        rd(2, 2, rd_v); chk("R2 set alias ignores fin", rd_v, 32'd0);
        wr(2, 3, 32'h4000); wr(2, 4, 32'd2); wr(2, 0, 32'h09);
        wr(3, 3, 32'h5000); wr(3, 4, 32'd1); wr(3, 0, 32'h09);
        mem_gnt = 1'b0;
        expect_beats(2, 32'h4000, 2, 1);
        expect_beats(3, 32'h5000, 1, 1);
        @(posedge clk); #1 per_req[3:2] = 2'b11;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R5 stall req", {31'd0, mem_req}, 32'd1);
            chk("R5 stall priority", {29'd0, mem_ch}, 32'd2);
            chk("R5 stall address", mem_addr, 32'h4000);
        end
        @(posedge clk); #1 mem_gnt = 1'b1;
        drain();
        rd(2, 2, rd_v); chk("R7 ch2 done", rd_v, 32'h45);

        // 16-bit channel with an odd count.
        wr(5, 3, 32'h6000); wr(5, 4, 32'd5); wr(5, 0, 32'h09);
        expect_beats(5, 32'h6000, 3, 2);
        @(posedge clk); #1 per_req[5] = 1'b1;
        drain();
        rd(5, 4, rd_v); chk("R6 half count zero", rd_v, 32'd0);
        rd(5, 3, rd_v); chk("R6 half address", rd_v, 32'h6006);

        // Abandon, then start only B: NXT_B follows, no irq without IE.
        wr(4, 3, 32'h7000); wr(4, 4, 32'd4); wr(4, 0, 32'h09);
        wr(4, 1, 32'h2B);
        rd(4, 2, rd_v); chk("R3 abandon", rd_v, 32'd0);
        wr(4, 5, 32'h7100); wr(4, 6, 32'd1); wr(4, 0, 32'h21);
        rd(4, 2, rd_v); chk("R9 next follows B", rd_v, 32'h61);
        rd(4, 7, rd_v); chk("R12 position B", rd_v, 32'h7100);
        expect_beats(4, 32'h7100, 1, 1);
        @(posedge clk); #1 per_req[4] = 1'b1;
        drain();
        rd(4, 2, rd_v); chk("R7 R8 ch4 done B", rd_v, 32'h11);
        chk("R11 no irq without IE", {31'd0, irq[4]}, 32'd0);

        // Out-of-range channel numbers.
        wr(6, 0, 32'hFFFF_FFFF);
        wr(7, 3, 32'h1234_5678);
        rd(6, 2, rd_v); chk("R13 ch6 reads zero", rd_v, 32'd0);
        rd(7, 3, rd_v); chk("R13 ch7 reads zero", rd_v, 32'd0);
        rd(0, 2, rd_v); chk("R13 ch0 untouched", rd_v, 32'h03);
        chk("R13 no request", {31'd0, mem_req}, 32'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule